// File: doc/BRIEF.md
# SDRAM Power-Up and Single-Burst Access Sequencer

This block sits between a simple request port and the command pins of a four-bank single-data-rate SDRAM. After reset it runs the mandatory start-up sequence. The clock enable is held low and only idle commands go out during a timed wait. The clock enable is raised part-way through that wait. Then come a precharge of every bank, two auto-refreshes and a mode register load, each followed by its own settling gap. A parameter moves the mode load ahead of the refreshes.

Once start-up is complete the block accepts one request at a time. A request carries a flat word address and a direction, and is taken on a valid/ready handshake. The address is split into bank, row and column. The block opens the row, waits the row-to-column delay and issues a read or write with automatic precharge. A one-cycle completion pulse follows after the burst and the precharge recovery have elapsed. The data bus is not handled here.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held, clock enable is low, chip select is high (inhibit), and `req_ready`, `init_done` and `done` are low.
- R2: After reset only NOP or inhibit appears until at least `CLK_MHZ*WAIT_US` cycles have passed. Clock enable rises inside that wait, near its midpoint, and never falls again. No command other than NOP is driven while clock enable is low.
- R3: The first real command after the wait is PRECHARGE with A10 high, so that all banks are closed.
- R4: With `MODE_FIRST`=0 the start-up commands are PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE. Each command is spaced from the one before it by exactly the gap of that earlier command: `T_RP` after a precharge, `T_RFC` after a refresh, `T_MRD` after a mode load.
- R5: With `MODE_FIRST`=1 the order is PRECHARGE, LOAD MODE, AUTO REFRESH, AUTO REFRESH, with the same spacing rule.
- R6: The mode word on A11:A0 has the burst-length code in A2:A0 (1→0, 2→1, 4→2, 8→3), the burst type in A3 (1 = interleaved), the CAS latency in A6:A4, and zeros in A11:A7. BA1:BA0 are zero.
- R7: `req_ready` stays low, and no ACTIVE, READ or WRITE is issued, until `init_done` is high. `init_done` rises only after the last start-up command's gap.
- R8: The flat address splits as {bank, row, column}, with bank in the top two bits, then a 12-bit row, then the column. ACTIVE drives the bank on BA1:BA0 and the row on A11:A0.
- R9: READ (for `req_write`=0) or WRITE (for `req_write`=1) follows ACTIVE exactly `T_RCD` cycles later, on the same bank. It has A10 high (auto-precharge), the column on A8:A0, and A9 and A11 low.
- R10: After acceptance `req_ready` is low. `done` is a one-cycle pulse `BURST_LEN+T_RP-1` cycles after the column command appears on the pins, and `req_ready` is high again in that same cycle.
- R11: Commands are encoded on {CS#, RAS#, CAS#, WE#}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. Inhibit has CS# high.
- R12: With `DQ_WIDTH`=32 the column is 8 bits wide. It goes on A7:A0 with A8 low, and the flat address is 22 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 23 (22 when DQ_WIDTH=32) | Flat word address {bank, row, column} |
| req_ready | output | 1 | Request can be accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| init_done | output | 1 | Start-up sequence finished |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row, column or mode address |

## Verification
A step counter or gap counter that is off by one shows up as a command spacing that is one cycle short or long. It also shows up as a command out of order on the pins, and it is visible the moment the command is driven. The bench therefore logs every non-NOP command with its cycle number and compares orders and exact gaps. A wrong address split or latch shows up on BA and A in the ACTIVE or column cycle of that very access. A wrong completion counter shifts `done` and the return of `req_ready` within the same access, so every access is checked before the next one starts.

// File: rtl/sdram_seq_pkg.sv
// Shared command encoding and helpers for the SDRAM sequencer.
// Assumes the {CS#, RAS#, CAS#, WE#} ordering used on the pins.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } cmd_t;

    // Burst length to its mode-register code; only 1, 2, 4 and 8 are meaningful.
    function automatic logic [2:0] bl_code(input int bl);
        case (bl)
            1:       return 3'd0;
            2:       return 3'd1;
            4:       return 3'd2;
            default: return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/sdram_addr_split.sv
// Splits a flat word address into {bank, row, column}.
// Assumes bank in the top bits and column in the bottom bits.
module sdram_addr_split #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    localparam int AW    = BANK_W + ROW_W + COL_W
) (
    input  logic [AW-1:0]     addr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o
);

    // Field slicing.
    always_comb begin
        col_o  = addr_i[COL_W-1:0];
        row_o  = addr_i[COL_W +: ROW_W];
        bank_o = addr_i[AW-1 -: BANK_W];
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Power-up sequencer: timed idle wait with clock enable raised at CKE_AT,
// then precharge-all, two refreshes and a mode load (order per MODE_FIRST),
// each followed by its gap. Assumes every gap parameter is at least 2.
module sdram_init_seq
    import sdram_seq_pkg::*;
#(
    parameter int          WAIT_CYC   = 5000,
    parameter int          CKE_AT     = 2500,
    parameter int          T_RP       = 2,
    parameter int          T_RFC      = 7,
    parameter int          T_MRD      = 2,
    parameter bit          MODE_FIRST = 1'b0,
    parameter logic [11:0] MODE_WORD  = 12'h022
) (
    input  logic        clk,
    input  logic        rst_n,
    output cmd_t        cmd_o,
    output logic [11:0] addr_o,
    output logic        cke_o,
    output logic        done_o
);

    localparam int CW = $clog2(WAIT_CYC + T_RP + T_RFC + T_MRD + 1);

    typedef enum logic [1:0] {S_WAIT, S_ISSUE, S_HOLD, S_DONE} st_t;

    st_t           st;
    logic [CW-1:0] cnt;
    logic [1:0]    step;
    cmd_t          cur;

    // Command belonging to each step of the start-up list.
    function automatic cmd_t step_cmd(input logic [1:0] s);
        case (s)
            2'd0:    return CMD_PRE;
            2'd1:    return MODE_FIRST ? CMD_LMR : CMD_REF;
            2'd2:    return CMD_REF;
            default: return MODE_FIRST ? CMD_REF : CMD_LMR;
        endcase
    endfunction

    // Hold count that follows a command.
    function automatic logic [CW-1:0] hold_of(input cmd_t c);
        case (c)
            CMD_PRE: return CW'(T_RP - 1);
            CMD_REF: return CW'(T_RFC - 1);
            default: return CW'(T_MRD - 1);
        endcase
    endfunction

    assign cur = step_cmd(step);

    // Sequence state, wait/gap counter and clock-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_WAIT;
            cnt   <= '0;
            step  <= '0;
            cke_o <= 1'b0;
        end else begin
            case (st)
                S_WAIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(CKE_AT)) cke_o <= 1'b1;
                    if (cnt == CW'(WAIT_CYC - 1)) st <= S_ISSUE;
                end
                S_ISSUE: begin
                    cnt <= hold_of(cur);
                    st  <= S_HOLD;
                end
                S_HOLD: begin
                    if (cnt == CW'(1)) begin
                        if (step == 2'd3) begin
                            st <= S_DONE;
                        end else begin
                            step <= step + 1'b1;
                            st   <= S_ISSUE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= S_DONE;
            endcase
        end
    end

    // Command and address for the current state.
    always_comb begin
        cmd_o  = (st == S_ISSUE) ? cur : CMD_NOP;
        addr_o = '0;
        if (cmd_o == CMD_PRE) addr_o[10] = 1'b1;
        if (cmd_o == CMD_LMR) addr_o = MODE_WORD;
    end

    assign done_o = (st == S_DONE);

endmodule

// File: rtl/sdram_access_fsm.sv
// Single-burst access engine: ACTIVE, T_RCD gap, READ/WRITE with
// auto-precharge, then a recovery of BURST_LEN+T_RP before returning idle.
// Assumes start_i is only raised while idle_o is high.
module sdram_access_fsm
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int T_RCD     = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic              idle_o,
    output cmd_t              cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic              done_o
);

    localparam int T_REC = BURST_LEN + T_RP;
    localparam int CW    = $clog2(T_RCD + T_REC + 1);

    typedef enum logic [2:0] {A_IDLE, A_ACT, A_RCD, A_COL, A_REC} st_t;

    st_t               st;
    logic [CW-1:0]     cnt;
    logic              wr_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    // Request latch, state walk and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= A_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                A_IDLE: if (start_i) begin
                    wr_q   <= write_i;
                    bank_q <= bank_i;
                    row_q  <= row_i;
                    col_q  <= col_i;
                    st     <= A_ACT;
                end
                A_ACT: begin
                    cnt <= CW'(T_RCD - 1);
                    st  <= A_RCD;
                end
                A_RCD: begin
                    if (cnt == CW'(1)) st <= A_COL;
                    else               cnt <= cnt - 1'b1;
                end
                A_COL: begin
                    cnt <= CW'(T_REC - 1);
                    st  <= A_REC;
                end
                default: begin
                    if (cnt == CW'(1)) begin
                        st     <= A_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Command, bank and address per state.
    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = bank_q;
        addr_o = '0;
        if (st == A_ACT) begin
            cmd_o  = CMD_ACT;
            addr_o = row_q;
        end else if (st == A_COL) begin
            cmd_o              = wr_q ? CMD_WR : CMD_RD;
            addr_o[COL_W-1:0]  = col_q;
            addr_o[10]         = 1'b1;
        end
    end

    assign idle_o = (st == A_IDLE);

endmodule

// File: rtl/sdram_seq.sv
// Top: start-up sequencer, address split and access engine with a
// registered command/address pin stage. Access commands only pass once
// start-up is done.
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_MHZ          = 50,
    parameter int WAIT_US          = 100,
    parameter int DQ_WIDTH         = 16,
    parameter int T_RP             = 2,
    parameter int T_RFC            = 7,
    parameter int T_MRD            = 2,
    parameter int T_RCD            = 2,
    parameter int BURST_LEN        = 4,
    parameter int CAS_LAT          = 2,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter bit MODE_FIRST       = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic [((DQ_WIDTH == 32) ? 22 : 23)-1:0] req_addr,
    output logic req_ready,
    output logic done,
    output logic init_done,
    output logic sd_cke,
    output logic sd_cs_n,
    output logic sd_ras_n,
    output logic sd_cas_n,
    output logic sd_we_n,
    output logic [1:0] sd_ba,
    output logic [11:0] sd_a
);

    localparam int          BANK_W    = 2;
    localparam int          ROW_W     = 12;
    localparam int          COL_W     = (DQ_WIDTH == 32) ? 8 : 9;
    localparam int          WAIT_CYC  = CLK_MHZ * WAIT_US;
    localparam int          CKE_AT    = WAIT_CYC / 2;
    localparam logic [2:0]  CL_BITS   = 3'(CAS_LAT);
    localparam logic [11:0] MODE_WORD = {5'd0, CL_BITS, BURST_INTERLEAVE, bl_code(BURST_LEN)};

    cmd_t              init_cmd, acc_cmd, cmd_q;
    logic [11:0]       init_a, acc_a;
    logic [BANK_W-1:0] acc_ba, bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              init_cke, acc_idle;

    sdram_init_seq #(
        .WAIT_CYC(WAIT_CYC), .CKE_AT(CKE_AT), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .MODE_FIRST(MODE_FIRST), .MODE_WORD(MODE_WORD)
    ) u_init (
        .clk(clk), .rst_n(rst_n), .cmd_o(init_cmd), .addr_o(init_a),
        .cke_o(init_cke), .done_o(init_done)
    );

    sdram_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr_i(req_addr), .bank_o(bank), .row_o(row), .col_o(col)
    );

    sdram_access_fsm #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
        .BURST_LEN(BURST_LEN), .T_RP(T_RP)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .start_i(req_valid && req_ready),
        .write_i(req_write), .bank_i(bank), .row_i(row), .col_i(col),
        .idle_o(acc_idle), .cmd_o(acc_cmd), .ba_o(acc_ba), .addr_o(acc_a),
        .done_o(done)
    );

    assign req_ready = init_done && acc_idle;

    // Pin register: selects the start-up or access source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cke <= 1'b0;
            cmd_q  <= CMD_INH;
            sd_ba  <= '0;
            sd_a   <= '0;
        end else begin
            sd_cke <= init_cke;
            if (!init_done) begin
                cmd_q <= init_cmd;
                sd_ba <= '0;
                sd_a  <= init_a;
            end else begin
                cmd_q <= acc_cmd;
                sd_ba <= acc_ba;
                sd_a  <= acc_a;
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_seq_chk.sv
// Temporal checks on the sequencer pins, bound into every sdram_seq.
module sdram_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sd_cke,
    input logic        sd_cs_n,
    input logic        sd_ras_n,
    input logic        sd_cas_n,
    input logic        sd_we_n,
    input logic [11:0] sd_a,
    input logic        init_done,
    input logic        req_ready,
    input logic        done
);

    logic [3:0] c;
    assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    p_cke_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);
    p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && c != 4'b0111) |-> sd_cke);
    p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> sd_a[10]);
    p_no_access_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0011 || c == 4'b0101 || c == 4'b0100) |-> init_done);
    p_ready_after_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);
    p_autoprecharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0101 || c == 4'b0100) |-> sd_a[10]);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

endmodule

bind sdram_seq sdram_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_a(sd_a), .init_done(init_done), .req_ready(req_ready), .done(done)
);

// File: tb/sim_sdram_seq.sv
// Bench: u0 default order with x16 columns, u1 mode-first order with x32
// columns. A negedge monitor logs every non-NOP command with its cycle.
module sim_sdram_seq;

    localparam int WAIT_CYC = 50 * 100;
    localparam int TRP = 2, TRFC = 7, TMRD = 2;
    localparam int TRCD0 = 3, BL0 = 4, CL0 = 2, IL0 = 0;
    localparam int TRCD1 = 2, BL1 = 8, CL1 = 3, IL1 = 1;

    typedef struct { int cyc; logic [3:0] cmd; logic [1:0] ba; logic [11:0] a; } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        v0 = 0, w0 = 0, v1 = 0, w1 = 0;
    logic [22:0] ad0 = '0;
    logic [21:0] ad1 = '0;
    logic rdy0, dn0, id0, cke0, cs0, ras0, cas0, we0;
    logic rdy1, dn1, id1, cke1, cs1, ras1, cas1, we1;
    logic [1:0]  ba0, ba1;
    logic [11:0] a0, a1;

    sdram_seq #(.T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_RCD(TRCD0), .BURST_LEN(BL0),
                .CAS_LAT(CL0), .BURST_INTERLEAVE(1'b0), .MODE_FIRST(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_write(w0), .req_addr(ad0),
        .req_ready(rdy0), .done(dn0), .init_done(id0), .sd_cke(cke0), .sd_cs_n(cs0),
        .sd_ras_n(ras0), .sd_cas_n(cas0), .sd_we_n(we0), .sd_ba(ba0), .sd_a(a0));

    sdram_seq #(.DQ_WIDTH(32), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_RCD(TRCD1),
                .BURST_LEN(BL1), .CAS_LAT(CL1), .BURST_INTERLEAVE(1'b1), .MODE_FIRST(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_write(w1), .req_addr(ad1),
        .req_ready(rdy1), .done(dn1), .init_done(id1), .sd_cke(cke1), .sd_cs_n(cs1),
        .sd_ras_n(ras1), .sd_cas_n(cas1), .sd_we_n(we1), .sd_ba(ba1), .sd_a(a1));

    int   checks = 0, errors = 0, cyc = 0;
    ent_t log0[$], log1[$];
    int   rise0 = -1, rise1 = -1, dcyc0 = 0, dcyc1 = 0, dcnt0 = 0, dcnt1 = 0;
    bit   drop0 = 0, drop1 = 0, early0 = 0, early1 = 0;

    // Command log, clock-enable and completion tracking.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cke0 && rise0 < 0) rise0 = cyc;
            if (!cke0 && rise0 >= 0) drop0 = 1;
            if (cke1 && rise1 < 0) rise1 = cyc;
            if (!cke1 && rise1 >= 0) drop1 = 1;
            if (rdy0 && !id0) early0 = 1;
            if (rdy1 && !id1) early1 = 1;
            if (!cs0 && {cs0, ras0, cas0, we0} != 4'b0111)
                log0.push_back('{cyc, {cs0, ras0, cas0, we0}, ba0, a0});
            if (!cs1 && {cs1, ras1, cas1, we1} != 4'b0111)
                log1.push_back('{cyc, {cs1, ras1, cas1, we1}, ba1, a1});
            if (dn0) begin dcyc0 = cyc; dcnt0++; end
            if (dn1) begin dcyc1 = cyc; dcnt1++; end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mode_word(input int bl, input int il, input int cl);
        logic [2:0] c = (bl == 1) ? 3'd0 : (bl == 2) ? 3'd1 : (bl == 4) ? 3'd2 : 3'd3;
        return {5'd0, 3'(cl), 1'(il), c};
    endfunction

    function automatic int gap_after(input logic [3:0] c);
        return (c == 4'b0010) ? TRP : (c == 4'b0001) ? TRFC : TMRD;
    endfunction

    function automatic ent_t get_ent(input int sel, input int i);
        return sel ? log1[i] : log0[i];
    endfunction

    task automatic check_init(input int sel);
        logic [3:0] exp[4];
        string rq = sel ? "R5" : "R4";
        int rise = sel ? rise1 : rise0;
        ent_t e, p;
        exp[0] = 4'b0010;
        exp[1] = sel ? 4'b0000 : 4'b0001;
        exp[2] = 4'b0001;
        exp[3] = sel ? 4'b0001 : 4'b0000;
        chk((sel ? log1.size() : log0.size()) == 4, "R7", "commands at init_done",
            sel ? log1.size() : log0.size(), 4);
        chk(!(sel ? early1 : early0), "R7", "ready before init", 1, 0);
        e = get_ent(sel, 0);
        chk(e.cmd == 4'b0010, "R3", "first command", e.cmd, 4'b0010);
        chk(e.a[10], "R3", "precharge A10", e.a[10], 1);
        chk(e.cyc >= WAIT_CYC, "R2", "first command cycle", e.cyc, WAIT_CYC);
        chk(rise > 0 && rise < WAIT_CYC && rise < e.cyc, "R2", "cke rise cycle", rise, WAIT_CYC / 2);
        chk(!(sel ? drop1 : drop0), "R2", "cke dropped", 1, 0);
        for (int k = 1; k < 4; k++) begin
            p = get_ent(sel, k - 1);
            e = get_ent(sel, k);
            chk(e.cmd == exp[k], rq, "order", e.cmd, exp[k]);
            chk(e.cyc - p.cyc == gap_after(p.cmd), rq, "gap", e.cyc - p.cyc, gap_after(p.cmd));
            if (e.cmd == 4'b0000) begin
                chk(e.a == (sel ? mode_word(BL1, IL1, CL1) : mode_word(BL0, IL0, CL0)),
                    "R6", "mode word", e.a, sel ? mode_word(BL1, IL1, CL1) : mode_word(BL0, IL0, CL0));
                chk(e.ba == 2'b00, "R6", "mode bank", e.ba, 0);
            end
        end
    endtask

    task automatic do_access(input int sel, input logic [22:0] addr, input bit wr);
        int colw = sel ? 8 : 9;
        int n0 = sel ? log1.size() : log0.size();
        int d0 = sel ? dcnt1 : dcnt0;
        int bank = int'(addr >> (12 + colw)) & 3;
        int row  = int'(addr >> colw) & 12'hFFF;
        int col  = int'(addr) & ((1 << colw) - 1);
        int trcd = sel ? TRCD1 : TRCD0;
        int blen = sel ? BL1 : BL0;
        int t = 0;
        ent_t ea, ec;
        logic [11:0] ecol;
        while (!(sel ? rdy1 : rdy0) && t < 100) begin @(negedge clk); t++; end
        if (sel) begin v1 = 1; w1 = wr; ad1 = addr[21:0]; end
        else     begin v0 = 1; w0 = wr; ad0 = addr; end
        @(posedge clk);
        @(negedge clk);
        v0 = 0; v1 = 0;
        chk(!(sel ? rdy1 : rdy0), "R10", "ready after accept", sel ? rdy1 : rdy0, 0);
        t = 0;
        while ((sel ? dcnt1 : dcnt0) == d0 && t < 100) begin @(negedge clk); t++; end
        chk((sel ? log1.size() : log0.size()) == n0 + 2, "R8", "commands per access",
            (sel ? log1.size() : log0.size()) - n0, 2);
        if ((sel ? log1.size() : log0.size()) < n0 + 2) return;
        ea = get_ent(sel, n0);
        ec = get_ent(sel, n0 + 1);
        ecol = 12'h400 | 12'(col);
        chk(ea.cmd == 4'b0011, "R11", "ACTIVE code", ea.cmd, 4'b0011);
        chk(ea.ba == 2'(bank) && ea.a == 12'(row), "R8", "bank/row", {ea.ba, ea.a}, (bank << 12) | row);
        chk(ec.cmd == (wr ? 4'b0100 : 4'b0101), "R9", "column command", ec.cmd, wr ? 4'b0100 : 4'b0101);
        chk(ec.ba == 2'(bank), "R9", "column bank", ec.ba, bank);
        chk(ec.a == ecol, sel ? "R12" : "R9", "column address", ec.a, ecol);
        chk(ec.cyc - ea.cyc == trcd, "R9", "ACTIVE to column", ec.cyc - ea.cyc, trcd);
        chk((sel ? dcyc1 : dcyc0) - ec.cyc == blen + TRP - 1, "R10", "column to done",
            (sel ? dcyc1 : dcyc0) - ec.cyc, blen + TRP - 1);
        chk(sel ? rdy1 : rdy0, "R10", "ready with done", 0, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        chk(!cke0 && cs0 && !rdy0 && !id0 && !dn0, "R1", "reset state u0",
            {cke0, cs0, rdy0, id0, dn0}, 5'b01000);
        chk(!cke1 && cs1 && !rdy1 && !id1, "R1", "reset state u1", {cke1, cs1, rdy1, id1}, 4'b0100);
        rst_n = 1;
        while (!(id0 && id1)) @(negedge clk);
        check_init(0);
        check_init(1);
        do_access(0, 23'd0, 1'b0);
        do_access(0, 23'h7FFFFF, 1'b1);
        do_access(0, {2'd2, 12'hFFF, 9'd0}, 1'b1);
        do_access(0, {2'd1, 12'd0, 9'h1FF}, 1'b0);
        for (int i = 0; i < 30; i++) do_access(0, 23'($urandom), 1'($urandom));
        do_access(1, {1'b0, 2'd3, 12'h5A5, 8'hFF}, 1'b0);
        do_access(1, {1'b0, 2'd0, 12'h001, 8'h00}, 1'b1);
        for (int i = 0; i < 4; i++) do_access(1, {1'b0, 22'($urandom)}, 1'($urandom));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule